// File: doc/BRIEF.md
# Tiled Sign-Magnitude Multiplier

This block multiplies two 65-bit sign-magnitude operands and returns their signed product as a 129-bit two's-complement word. Bit 64 of each operand is the sign and bits 63:0 are the magnitude. The two magnitudes are multiplied from a grid of small, unequal tiles. Operand A is cut into rows of 24 bits at bit offsets 0, 24 and 48, so the top row is 16 bits wide. Operand B is cut into columns of 17 bits at offsets 0, 17, 34 and 51, so the top column is 13 bits wide. Each tile therefore fits a 25x18 hardware multiplier primitive, and the top-corner tile is only 16x13.

Each A row forms a row sum from its four tiles. Neighbouring tiles are weighted 17 bits apart. The three row sums G0, G1 and G2 are then joined as G0 + (G2 << 48), and G1 << 24 is added to that. A parameter picks one of two build variants. The parallel variant has one tile row per A row and takes one operation on every cycle. The shared variant computes G0 and G2 one cycle apart on a single tile row, and a register stage on G1 keeps the three sums aligned. In both variants the result appears exactly seven cycles after the operands are taken.

Top module: `smul_tiled`

## Requirements
- R1: `in_a` and `in_b` carry the sign in bit 64 and the magnitude in bits 63:0. `out_prod` is the signed product as a 129-bit two's-complement value.
- R2: The magnitude of the result is the exact product of the two 64-bit magnitudes for every value, including the all-ones magnitude.
- R3: When both magnitudes are nonzero, the result is negative exactly when the operand signs differ (their XOR). When either magnitude is zero, `out_prod` is all zeros whatever the signs.
- R4: An operation taken on the clock edge that ends cycle c gives `out_valid` high in cycle c+7, with its product. `out_valid` is low in every other cycle.
- R5: With `SHARED` = 0, an operation is taken on every cycle in which `in_valid` is high. Back-to-back operations come out on consecutive cycles, in order.
- R6: With `SHARED` = 1, `in_valid` in the cycle right after a taken operation is ignored and produces no result. `out_valid` is never high on two consecutive cycles.
- R7: While `rst_n` is low, `out_valid` is low and `in_valid` is ignored. No result comes out for operands offered during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on `in_a`/`in_b` are offered this cycle |
| in_a | input | 65 | Operand A: sign in bit 64, magnitude in bits 63:0 |
| in_b | input | 65 | Operand B: sign in bit 64, magnitude in bits 63:0 |
| out_valid | output | 1 | `out_prod` holds a result this cycle |
| out_prod | output | 129 | Signed product, two's complement |

## Verification
Both variants are driven with the same stimulus, and every cycle is compared with a behavioural model built from queues.

- **Corner operands:** zero magnitudes with either sign and all-ones magnitudes. Zero magnitudes show whether a negative zero leaks out. All-ones magnitudes set every carry across the tile seams and the full 128-bit width.
- **Mixed signs:** these separate the sign path from the magnitude path.
- **Single-tile operands:** operands with only the top row or top column set reach the trimmed corner tile alone.
- **Dense bursts and random gaps:** bursts of consecutive valids tell the parallel variant, which must take all of them, from the shared one, which must drop every second one. Random operands with random gaps check ordering and latency under mixed traffic.

// File: rtl/smul_pkg.sv
package smul_pkg;
    localparam int MAG_W   = 64;                    // magnitude bits per operand
    localparam int OP_W    = MAG_W + 1;             // sign + magnitude
    localparam int A_CH    = 24;                    // A row width (25-bit port side)
    localparam int B_CH    = 17;                    // B column width (18-bit port side)
    localparam int PROD_W  = 2 * MAG_W;             // magnitude product width
    localparam int RES_W   = PROD_W + 1;            // signed result width
    localparam int TOP_A   = MAG_W - 2 * A_CH;      // width of the top A row
    localparam int LAT     = 7;                     // input-to-output register count
endpackage

// File: rtl/smul_tile_row.sv
module smul_tile_row #(
    parameter int A_W  = 24,
    parameter int B_W  = 64,
    parameter int B_CH = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vin,
    input  logic [A_W-1:0]       a_row,
    input  logic [B_W-1:0]       b_all,
    output logic [A_W+B_W-1:0]   row_sum
);
    localparam int NB     = (B_W + B_CH - 1) / B_CH;
    localparam int LAST_W = B_W - B_CH * (NB - 1);
    localparam int PP_W   = A_W + B_CH;
    localparam int S_W    = A_W + B_W;

    typedef struct packed {
        logic [NB-1:0][PP_W-1:0] pp;
        logic [S_W-1:0]          sum;
        logic [1:0]              v;
    } row_t;

    row_t cur_q, nxt_d;
    logic [NB-1:0][PP_W-1:0] tile_d;

    // one tile per B column; the last column is narrower
    for (genvar j = 0; j < NB; j++) begin : g_tile
        localparam int W = (j == NB - 1) ? LAST_W : B_CH;
        assign tile_d[j] = PP_W'(a_row) * PP_W'(b_all[j*B_CH +: W]);
    end

    always_comb begin
        logic [S_W-1:0] acc;
        nxt_d    = cur_q;
        nxt_d.pp = tile_d;
        nxt_d.v  = {cur_q.v[0], vin};
        acc      = '0;
        for (int j = 0; j < NB; j++) begin
            acc = acc + (S_W'(cur_q.pp[j]) << (j * B_CH));
        end
        nxt_d.sum = acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign row_sum = cur_q.sum;

    // R2
    row_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.v[1] |-> (cur_q.sum == S_W'(S_W'($past(a_row, 2)) * S_W'($past(b_all, 2)))));
endmodule

// File: rtl/smul_tiled.sv
module smul_tiled
    import smul_pkg::*;
#(
    parameter bit SHARED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_a,
    input  logic [OP_W-1:0]   in_b,
    output logic              out_valid,
    output logic [RES_W-1:0]  out_prod
);
    localparam int G_W  = A_CH + MAG_W;
    localparam int G2_W = TOP_A + MAG_W;

    typedef struct packed {
        logic [LAT-1:0]    vs;     // valid per stage, index 0 = operand stage
        logic [LAT-2:0]    sg;     // result sign per stage
        logic              ph;     // shared variant: second pass (top A row)
        logic [MAG_W-1:0]  a;
        logic [MAG_W-1:0]  b;
        logic [PROD_W-1:0] g0;
        logic [PROD_W-1:0] g1;
        logic [PROD_W-1:0] g2;
        logic [PROD_W-1:0] s0;
        logic [PROD_W-1:0] g1d;
        logic [PROD_W-1:0] mag;
        logic [RES_W-1:0]  prod;
    } pipe_t;

    pipe_t cur_q, nxt_d;
    logic accept, busy;
    logic [A_CH-1:0] row0_in;
    logic [G_W-1:0]  grp0, grp1;
    logic [G2_W-1:0] grp2;
    logic [PROD_W-1:0] g2_live;

    assign busy    = SHARED && cur_q.vs[0];
    assign accept  = in_valid && !busy && rst_n;
    assign row0_in = cur_q.ph ? A_CH'(cur_q.a[MAG_W-1:2*A_CH]) : cur_q.a[A_CH-1:0];

    smul_tile_row #(.A_W(A_CH), .B_W(MAG_W), .B_CH(B_CH)) u_row0 (
        .clk(clk), .rst_n(rst_n), .vin(cur_q.vs[0] | cur_q.ph),
        .a_row(row0_in), .b_all(cur_q.b), .row_sum(grp0));

    smul_tile_row #(.A_W(A_CH), .B_W(MAG_W), .B_CH(B_CH)) u_row1 (
        .clk(clk), .rst_n(rst_n), .vin(cur_q.vs[0]),
        .a_row(cur_q.a[2*A_CH-1:A_CH]), .b_all(cur_q.b), .row_sum(grp1));

    if (!SHARED) begin : g_row2
        smul_tile_row #(.A_W(TOP_A), .B_W(MAG_W), .B_CH(B_CH)) u_row2 (
            .clk(clk), .rst_n(rst_n), .vin(cur_q.vs[0]),
            .a_row(cur_q.a[MAG_W-1:2*A_CH]), .b_all(cur_q.b), .row_sum(grp2));
        assign g2_live = cur_q.g2;
    end else begin : g_norow2
        assign grp2    = '0;
        assign g2_live = PROD_W'(grp0);   // second pass of the shared row
    end

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.vs = {cur_q.vs[LAT-2:0], accept};
        nxt_d.sg = {cur_q.sg[LAT-3:0], (in_a[OP_W-1] ^ in_b[OP_W-1])};
        nxt_d.ph = SHARED && cur_q.vs[0];
        if (accept) begin
            nxt_d.a = in_a[MAG_W-1:0];
            nxt_d.b = in_b[MAG_W-1:0];
        end
        // alignment stage: extra register on G1 in the shared variant
        nxt_d.g0   = PROD_W'(grp0);
        nxt_d.g1   = PROD_W'(grp1);
        nxt_d.g2   = PROD_W'(grp2);
        nxt_d.s0   = cur_q.g0 + (g2_live << (2 * A_CH));
        nxt_d.g1d  = cur_q.g1;
        nxt_d.mag  = cur_q.s0 + (cur_q.g1d << A_CH);
        nxt_d.prod = cur_q.sg[LAT-2] ? -{1'b0, cur_q.mag} : {1'b0, cur_q.mag};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_valid = cur_q.vs[LAT-1];
    assign out_prod  = cur_q.prod;

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(accept, 7));

    // R3
    sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_prod[RES_W-1] ==
            $past((in_a[OP_W-1] ^ in_b[OP_W-1]) && (|in_a[MAG_W-1:0]) && (|in_b[MAG_W-1:0]), 7)));

    // R3
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_a[MAG_W-1:0] == '0, 7)) |-> (out_prod == '0));

    // R6
    shared_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SHARED && out_valid) |=> !out_valid);
endmodule

// File: tb/smul_tiled_test.sv
`timescale 1ns/1ps
module smul_tiled_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [64:0]  in_a = '0, in_b = '0;
    logic         ov_p, ov_s;
    logic [128:0] op_p, op_s;

    always #2 clk = ~clk;   // 250 MHz

    smul_tiled #(.SHARED(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(ov_p), .out_prod(op_p));
    smul_tiled #(.SHARED(1'b1)) uut_sh (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(ov_s), .out_prod(op_s));

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit acc_prev = 0;
    int           due_p[$], due_s[$];
    logic [128:0] val_p[$], val_s[$];
    string        tag_p[$], tag_s[$];

    function automatic logic [128:0] ref_mul(logic [64:0] a, logic [64:0] b);
        logic [127:0] m;
        m = 128'(a[63:0]) * 128'(b[63:0]);
        if (a[64] ^ b[64]) return -{1'b0, m};
        return {1'b0, m};
    endfunction

    function automatic string tag_of(logic [64:0] a, logic [64:0] b);
        if ((a[64] ^ b[64]) || a[63:0] == 0 || b[63:0] == 0) return "R3";
        return "R2";
    endfunction

    task automatic chk(bit ok, string req, string what, logic [128:0] act, logic [128:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model: record accepted operations with the cycle they are due
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) acc_prev = 0;
        else if (in_valid) begin
            due_p.push_back(cyc + 6); val_p.push_back(ref_mul(in_a, in_b)); tag_p.push_back(tag_of(in_a, in_b));
            if (!acc_prev) begin
                due_s.push_back(cyc + 6); val_s.push_back(ref_mul(in_a, in_b)); tag_s.push_back(tag_of(in_a, in_b));
                acc_prev = 1;
            end else acc_prev = 0;
        end else acc_prev = 0;
    end

    always @(negedge clk) begin
        bit ev;
        if (!rst_n) begin
            chk(ov_p == 0, "R7", "parallel valid in reset", 129'(ov_p), 0);
            chk(ov_s == 0, "R7", "shared valid in reset", 129'(ov_s), 0);
        end else begin
            ev = (due_p.size() > 0 && due_p[0] == cyc);
            chk(ov_p == ev, ev ? "R5" : "R4", "parallel out_valid", 129'(ov_p), 129'(ev));
            if (ev) begin
                if (ov_p) chk(op_p == val_p[0], tag_p[0], "parallel product (R1)", op_p, val_p[0]);
                void'(due_p.pop_front()); void'(val_p.pop_front()); void'(tag_p.pop_front());
            end
            ev = (due_s.size() > 0 && due_s[0] == cyc);
            chk(ov_s == ev, ev ? "R4" : "R6", "shared out_valid", 129'(ov_s), 129'(ev));
            if (ev) begin
                if (ov_s) chk(op_s == val_s[0], tag_s[0], "shared product (R1)", op_s, val_s[0]);
                void'(due_s.pop_front()); void'(val_s.pop_front()); void'(tag_s.pop_front());
            end
        end
    end

    task automatic drive(bit v, logic [64:0] a, logic [64:0] b);
        @(negedge clk);
        in_valid = v; in_a = a; in_b = b;
    endtask

    function automatic logic [64:0] rnd65();
        return 65'({$urandom, $urandom, $urandom});
    endfunction

    localparam logic [63:0] ONES = '1;

    initial begin
        // R7: operands offered during reset must not produce results
        for (int i = 0; i < 6; i++) drive(1, rnd65(), rnd65());
        @(negedge clk); rst_n = 1; in_valid = 0;
        drive(0, '0, '0);
        // corners, spaced out
        drive(1, {1'b0, 64'd0}, {1'b0, 64'd0});        drive(0, '0, '0);
        drive(1, {1'b1, 64'd0}, {1'b0, 64'd12345});    drive(0, '0, '0);
        drive(1, {1'b0, ONES}, {1'b1, 64'd0});         drive(0, '0, '0);
        drive(1, {1'b0, ONES}, {1'b0, ONES});          drive(0, '0, '0);
        drive(1, {1'b1, ONES}, {1'b0, ONES});          drive(0, '0, '0);
        drive(1, {1'b1, ONES}, {1'b1, ONES});          drive(0, '0, '0);
        drive(1, {1'b0, 64'd1}, {1'b1, ONES});         drive(0, '0, '0);
        drive(1, {1'b0, 16'hFFFF, 48'd0}, {1'b0, 13'h1FFF, 51'd0}); drive(0, '0, '0);
        drive(1, {1'b1, 64'h8000_0000_0000_0000}, {1'b0, 64'h8000_0000_0000_0001});
        drive(0, '0, '0);
        // dense burst: shared variant must drop every second operation
        for (int i = 0; i < 9; i++) drive(1, rnd65(), rnd65());
        drive(0, '0, '0);
        // random traffic with random gaps
        for (int i = 0; i < 400; i++) drive(($urandom % 10) < 7, rnd65(), rnd65());
        for (int i = 0; i < 14; i++) drive(0, '0, '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule